// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of one single-data-rate SDRAM device from reset until the device is ready for normal traffic. It first holds the bus idle for a stabilization interval, with clock enable high and the data masks set. It then issues the fixed power-up command set: a precharge of every bank, two auto-refresh commands and a mode-register load. Each command is followed by a minimum gap before the next one. When the last gap has run out, the block raises a ready flag. That flag stays high until the next reset, so a memory controller can take over the pins from then on.

Every timing figure is a parameter. The stabilization time, the precharge recovery and the refresh cycle time are given in nanoseconds. The mode-register recovery is given in clock cycles. Elaboration turns the nanosecond values into cycle counts by rounding up against the clock period, and never uses fewer than one cycle. A parameter selects whether the mode-register load comes straight after the precharge or after the two refreshes. The mode code is taken from an input word at the moment the load command goes out.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is low, and for S cycles after it is released, the command code {cs_n,ras_n,cas_n,we_n} is 4'b0111 (NOP). S = max(1, ceil(STABLE_NS*1000 / CLK_PERIOD_PS)). The first command appears in the cycle after rising edge S, counting the first edge after release as edge 1.
- R2: sd_cke is 1 and every bit of sd_dqm is 1 in every cycle, during reset and after it.
- R3: The precharge command has code 4'b0010. It drives address bit 10 high, all other address bits low and the bank address to zero.
- R4: The block issues exactly two auto-refresh commands with code 4'b0001, each with the address and bank address at zero.
- R5: The mode-register load has code 4'b0000. It drives sd_addr equal to mode_word and the bank address to zero.
- R6: With MRS_FIRST=0 the order is precharge, refresh, refresh, load. With MRS_FIRST=1 it is precharge, load, refresh, refresh. No other command is issued.
- R7: The next command comes exactly G cycles after the previous one. G = max(1, ceil(T*1000/CLK_PERIOD_PS)), where T is TRP_NS after a precharge and TRFC_NS after a refresh. After a load, G = max(1, TMRD_CK). With G = 1, commands go out on back-to-back cycles.
- R8: Every cycle between commands is NOP. init_done rises exactly G cycles after the fourth command, where G is the gap that belongs to that command.
- R9: Once init_done is high it stays high, and the pins stay at NOP, whatever mode_word does, until reset.
- R10: Asserting reset at any point returns the outputs to NOP with init_done low at once. The next release runs the whole sequence again from the stabilization interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_word | input | ADDR_W | Mode code driven on the address pins by the load command |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_addr | output | ADDR_W | Address pins |
| sd_ba | output | BA_W | Bank address |
| sd_dqm | output | DQM_W | Data mask pins |
| init_done | output | 1 | Sequence finished; controller may start |

## Verification
The assertions assume that reset is applied cleanly at start-up. They also assume that mode_word is steady during any cycle in which the load command is on the pins, because the load check compares the address pins with that input in the same cycle. The bench changes mode_word only while reset is low, or after init_done has risen. It then checks at the pins that those later changes produce no command. One instance uses gaps long enough to leave idle cycles, and a second instance uses gaps that reduce to one cycle. The bench asserts reset once in the middle of a sequence to exercise the restart.

// File: rtl/sdram_init_pkg.sv
`timescale 1ns/1ps
package sdram_init_pkg;

  // Pin code on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [1:0] {
    PH_STABLE = 2'd0,
    PH_CMD    = 2'd1,
    PH_GAP    = 2'd2,
    PH_DONE   = 2'd3
  } init_phase_e;

  // Round a nanosecond figure up to whole clock cycles, never below one
  function automatic int ns_to_cyc(input longint t_ns, input longint per_ps);
    longint c;
    c = (t_ns * 64'd1000 + per_ps - 64'd1) / per_ps;
    if (c < 64'd1) c = 64'd1;
    return int'(c);
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int min_of(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_init_steps.sv
`timescale 1ns/1ps
module sdram_init_steps
  import sdram_init_pkg::*;
#(
  parameter bit MRS_FIRST = 1'b0,
  parameter int CNT_W     = 8,
  parameter int GAP_RP    = 1,
  parameter int GAP_RFC   = 1,
  parameter int GAP_MRD   = 2
) (
  input  logic [1:0]       step,
  output sd_cmd_e          kind,
  output logic [CNT_W-1:0] gap,
  output logic             is_last
);

  localparam logic [CNT_W-1:0] G_RP  = CNT_W'(GAP_RP);
  localparam logic [CNT_W-1:0] G_RFC = CNT_W'(GAP_RFC);
  localparam logic [CNT_W-1:0] G_MRD = CNT_W'(GAP_MRD);

  // Order table chosen by parameter
  generate
    if (MRS_FIRST) begin : g_mrs_early
      always_comb begin
        case (step)
          2'd0:    kind = CMD_PRE;
          2'd1:    kind = CMD_LMR;
          default: kind = CMD_REF;
        endcase
      end
    end else begin : g_mrs_late
      always_comb begin
        case (step)
          2'd0:    kind = CMD_PRE;
          2'd3:    kind = CMD_LMR;
          default: kind = CMD_REF;
        endcase
      end
    end
  endgenerate

  always_comb begin
    case (kind)
      CMD_PRE: gap = G_RP;
      CMD_REF: gap = G_RFC;
      CMD_LMR: gap = G_MRD;
      default: gap = G_MRD;
    endcase
  end

  assign is_last = (step == 2'd3);

endmodule

// File: rtl/sdram_init_fsm.sv
`timescale 1ns/1ps
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int STABLE_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] step_gap,
  input  logic             step_last,
  output logic [1:0]       step,
  output logic             cmd_fire,
  output logic             gap_end,
  output logic             seq_done
);

  localparam logic [CNT_W-1:0] STABLE_LOAD = CNT_W'(STABLE_CYC - 1);

  init_phase_e      phase;
  logic [CNT_W-1:0] cnt;
  logic             short_gap;

  assign short_gap = (step_gap <= CNT_W'(1));
  assign cmd_fire  = (phase == PH_CMD);
  assign seq_done  = (phase == PH_DONE);
  // Cycle in which the wait after a command finishes
  assign gap_end   = (cmd_fire && short_gap) ||
                     (phase == PH_GAP && cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_STABLE;
      cnt   <= STABLE_LOAD;
      step  <= 2'd0;
    end else begin
      case (phase)
        PH_STABLE: begin
          if (cnt == '0) phase <= PH_CMD;
          else           cnt   <= cnt - 1'b1;
        end
        PH_CMD: begin
          if (short_gap) begin
            if (step_last) phase <= PH_DONE;
            else           step  <= step + 2'd1;
          end else begin
            phase <= PH_GAP;
            cnt   <= step_gap - CNT_W'(2);
          end
        end
        PH_GAP: begin
          if (cnt == '0) begin
            if (step_last) begin
              phase <= PH_DONE;
            end else begin
              step  <= step + 2'd1;
              phase <= PH_CMD;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_DONE;
      endcase
    end
  end

endmodule

// File: rtl/sdram_cmd_drive.sv
`timescale 1ns/1ps
module sdram_cmd_drive
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int BA_W    = 2,
  parameter int DQM_W   = 2,
  parameter int A10_BIT = 10
) (
  input  logic              fire,
  input  sd_cmd_e           kind,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              cke,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic [DQM_W-1:0]  dqm
);

  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << A10_BIT;

  sd_cmd_e code;

  always_comb begin
    code = CMD_NOP;
    addr = '0;
    if (fire) begin
      code = kind;
      case (kind)
        CMD_PRE: addr = ALL_BANKS;
        CMD_LMR: addr = mode_word;
        default: addr = '0;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = code;
  assign ba  = '0;
  assign cke = 1'b1;
  assign dqm = '1;

endmodule

// File: rtl/sdram_pwrup_seq.sv
`timescale 1ns/1ps
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int BA_W          = 2,
  parameter int DQM_W         = 2,
  parameter int A10_BIT       = 10,
  parameter int CLK_PERIOD_PS = 4000,
  parameter int STABLE_NS     = 100000,
  parameter int TRP_NS        = 20,
  parameter int TRFC_NS       = 66,
  parameter int TMRD_CK       = 2,
  parameter bit MRS_FIRST     = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_cke,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              init_done
);

  localparam int STABLE_CYC = ns_to_cyc(STABLE_NS, CLK_PERIOD_PS);
  localparam int GAP_RP     = ns_to_cyc(TRP_NS, CLK_PERIOD_PS);
  localparam int GAP_RFC    = ns_to_cyc(TRFC_NS, CLK_PERIOD_PS);
  localparam int GAP_MRD    = max_of(1, TMRD_CK);
  localparam int MAX_CYC    = max_of(max_of(STABLE_CYC, GAP_RP),
                                     max_of(GAP_RFC, GAP_MRD));
  localparam int CNT_W      = $clog2(MAX_CYC + 1) + 1;
  localparam int GAP_MIN    = min_of(min_of(GAP_RP, GAP_RFC), GAP_MRD);

  logic [1:0]       step;
  sd_cmd_e          kind;
  logic [CNT_W-1:0] step_gap;
  logic             step_last;
  logic             cmd_fire;
  logic             gap_end;
  logic             seq_done;

  sdram_init_steps #(
    .MRS_FIRST (MRS_FIRST),
    .CNT_W     (CNT_W),
    .GAP_RP    (GAP_RP),
    .GAP_RFC   (GAP_RFC),
    .GAP_MRD   (GAP_MRD)
  ) u_steps (
    .step    (step),
    .kind    (kind),
    .gap     (step_gap),
    .is_last (step_last)
  );

  sdram_init_fsm #(
    .CNT_W      (CNT_W),
    .STABLE_CYC (STABLE_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_gap  (step_gap),
    .step_last (step_last),
    .step      (step),
    .cmd_fire  (cmd_fire),
    .gap_end   (gap_end),
    .seq_done  (seq_done)
  );

  sdram_cmd_drive #(
    .ADDR_W  (ADDR_W),
    .BA_W    (BA_W),
    .DQM_W   (DQM_W),
    .A10_BIT (A10_BIT)
  ) u_drive (
    .fire      (cmd_fire),
    .kind      (kind),
    .mode_word (mode_word),
    .cs_n      (sd_cs_n),
    .ras_n     (sd_ras_n),
    .cas_n     (sd_cas_n),
    .we_n      (sd_we_n),
    .cke       (sd_cke),
    .addr      (sd_addr),
    .ba        (sd_ba),
    .dqm       (sd_dqm)
  );

  assign init_done = seq_done;

endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
`timescale 1ns/1ps
module sdram_pwrup_seq_chk #(
  parameter int ADDR_W  = 12,
  parameter int BA_W    = 2,
  parameter int DQM_W   = 2,
  parameter int A10_BIT = 10,
  parameter int GAP_MIN = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mode_word,
  input logic [3:0]        pins,
  input logic              cke,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba,
  input logic [DQM_W-1:0]  dqm,
  input logic              cmd_fire,
  input logic              gap_end,
  input logic              done
);

  localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << A10_BIT;

  logic       is_cmd;
  logic [2:0] issued;
  logic [7:0] since;

  assign is_cmd = (pins != 4'b0111);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issued <= '0;
      since  <= '0;
    end else begin
      if (is_cmd) begin
        issued <= issued + 3'd1;
        since  <= 8'd1;
      end else if (since != 8'hFF && since != 8'd0) begin
        since <= since + 8'd1;
      end
    end
  end

  p_pins_static_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cke && (&dqm));

  p_pre_form_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0010) |-> (addr == PRE_ADDR && ba == '0));

  p_ref_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0001) |-> (addr == '0 && ba == '0));

  p_lmr_form_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0000) |-> (addr == mode_word && ba == '0));

  p_four_cmds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (issued == 3'd4));

  p_min_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && issued != 3'd0) |-> (since >= 8'(GAP_MIN)));

  p_fire_on_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |-> is_cmd);

  p_done_after_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(gap_end));

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !is_cmd);

endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
  .ADDR_W  (ADDR_W),
  .BA_W    (BA_W),
  .DQM_W   (DQM_W),
  .A10_BIT (A10_BIT),
  .GAP_MIN (GAP_MIN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_word (mode_word),
  .pins      ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
  .cke       (sd_cke),
  .addr      (sd_addr),
  .ba        (sd_ba),
  .dqm       (sd_dqm),
  .cmd_fire  (cmd_fire),
  .gap_end   (gap_end),
  .done      (init_done)
);

// File: tb/sdram_pwrup_seq_tb.sv
`timescale 1ns/1ps
module sdram_pwrup_seq_tb;

  localparam int PER_PS  = 4000;
  localparam int AW      = 12;
  localparam int BAW     = 2;
  localparam int DW      = 2;
  localparam int STAB_NS = 2000;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  typedef struct {
    int         at;
    logic [3:0] cmd;
    logic [AW-1:0] addr;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] mode_word = 12'h032;
  always #2 clk = ~clk;

  logic [3:0]    p0, p1;
  logic          cke0, cke1, dn0, dn1;
  logic [AW-1:0] a0, a1;
  logic [BAW-1:0] b0, b1;
  logic [DW-1:0] m0, m1;

  sdram_pwrup_seq #(.CLK_PERIOD_PS(PER_PS), .STABLE_NS(STAB_NS),
    .TRP_NS(20), .TRFC_NS(66), .TMRD_CK(2), .MRS_FIRST(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word),
    .sd_cs_n(p0[3]), .sd_ras_n(p0[2]), .sd_cas_n(p0[1]), .sd_we_n(p0[0]),
    .sd_cke(cke0), .sd_addr(a0), .sd_ba(b0), .sd_dqm(m0), .init_done(dn0));

  sdram_pwrup_seq #(.CLK_PERIOD_PS(PER_PS), .STABLE_NS(STAB_NS),
    .TRP_NS(3), .TRFC_NS(0), .TMRD_CK(2), .MRS_FIRST(1'b1)) u_dut_early (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word),
    .sd_cs_n(p1[3]), .sd_ras_n(p1[2]), .sd_cas_n(p1[1]), .sd_we_n(p1[0]),
    .sd_cke(cke1), .sd_addr(a1), .sd_ba(b1), .sd_dqm(m1), .init_done(dn1));

  int n_checks = 0;
  int n_fail   = 0;
  int edge_no  = 0;
  int done_at[2];
  int s_cyc;
  bit finished = 1'b0;
  ev_t sb[2][$];

  always @(posedge clk or negedge rst_n)
    if (!rst_n) edge_no <= 0;
    else        edge_no <= edge_no + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Cycle count by stepping through periods until the time is covered
  function automatic int cyc(input int t_ns);
    int n = 0;
    while (n * PER_PS < t_ns * 1000) n++;
    if (n == 0) n = 1;
    return n;
  endfunction

  task automatic push_run(input logic [AW-1:0] mw);
    int t;
    sb[0].delete();
    sb[1].delete();
    s_cyc = cyc(STAB_NS);
    // default order, 20/66 ns gaps
    t = s_cyc;
    sb[0].push_back('{t, C_PRE, 12'h400});
    t += cyc(20);
    sb[0].push_back('{t, C_REF, 12'h000});
    t += cyc(66);
    sb[0].push_back('{t, C_REF, 12'h000});
    t += cyc(66);
    sb[0].push_back('{t, C_LMR, mw});
    done_at[0] = t + 2;
    // early load, one-cycle gaps
    t = s_cyc;
    sb[1].push_back('{t, C_PRE, 12'h400});
    t += cyc(3);
    sb[1].push_back('{t, C_LMR, mw});
    t += 2;
    sb[1].push_back('{t, C_REF, 12'h000});
    t += cyc(0);
    sb[1].push_back('{t, C_REF, 12'h000});
    done_at[1] = t + cyc(0);
  endtask

  task automatic mon(input int id, input logic [3:0] c, input logic [AW-1:0] a,
                     input logic [BAW-1:0] b, input logic k, input logic [DW-1:0] m,
                     input logic d);
    ev_t e;
    if (!(k && (&m))) chk(1'b0, "R2", "cke/dqm", {k, m}, 7);
    if (c != C_NOP) begin
      if (sb[id].size() == 0) begin
        chk(1'b0, "R9", $sformatf("extra command inst%0d", id), c, C_NOP);
      end else begin
        e = sb[id].pop_front();
        chk(edge_no == e.at, (e.cmd == C_PRE) ? "R1" : "R7",
            $sformatf("command edge inst%0d", id), edge_no, e.at);
        chk(c == e.cmd, "R6", $sformatf("command code inst%0d", id), c, e.cmd);
        chk(a == e.addr, (c == C_PRE) ? "R3" : (c == C_LMR) ? "R5" : "R4",
            $sformatf("address inst%0d", id), a, e.addr);
        chk(b == '0, "R5", $sformatf("bank inst%0d", id), b, 0);
      end
    end
    if (edge_no == done_at[id] - 1) chk(d == 1'b0, "R8", "done early", d, 0);
    if (edge_no == done_at[id])     chk(d == 1'b1, "R8", "done edge", d, 1);
    if (edge_no > done_at[id] && !d) chk(1'b0, "R9", "done dropped", d, 1);
  endtask

  // Monitor: compares pins against the scoreboard away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      mon(0, p0, a0, b0, cke0, m0, dn0);
      mon(1, p1, a1, b1, cke1, m1, dn1);
    end
  end

  task automatic check_idle(input string req);
    chk(p0 == C_NOP && p1 == C_NOP, req, "reset pins", {p0, p1}, {C_NOP, C_NOP});
    chk(!dn0 && !dn1, req, "reset done", {dn0, dn1}, 0);
    chk(cke0 && cke1 && (&m0) && (&m1), "R2", "reset cke/dqm",
        {cke0, cke1, m0, m1}, 8'h3F);
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    done_at[0] = 1 << 30;
    done_at[1] = 1 << 30;
    wait_edges(3);
    check_idle("R1");
    // run 1: full sequence, mode code 0x032
    push_run(12'h032);
    rst_n = 1'b1;
    @(negedge clk);
    while (edge_no < s_cyc - 1) @(negedge clk);
    chk(p0 == C_NOP && p1 == C_NOP, "R1", "stabilization nop", {p0, p1}, 8'h77);
    while (edge_no < done_at[0] + 5) @(negedge clk);
    // R9: mode_word moves after done, pins must stay quiet
    for (int i = 0; i < 40; i++) begin
      mode_word = 12'(i * 37);
      @(negedge clk);
    end
    chk(sb[0].size() == 0 && sb[1].size() == 0, "R6", "missing commands",
        sb[0].size() + sb[1].size(), 0);
    // R10: reset in the middle of the sequence, then restart
    rst_n = 1'b0;
    mode_word = 12'h027;
    push_run(12'h027);
    rst_n = 1'b1;
    while (edge_no < s_cyc + 10) @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check_idle("R10");
    @(negedge clk);
    push_run(12'h027);
    rst_n = 1'b1;
    @(negedge clk);
    while (edge_no < done_at[0] + 20) @(negedge clk);
    chk(sb[0].size() == 0 && sb[1].size() == 0, "R10", "restart commands",
        sb[0].size() + sb[1].size(), 0);
    chk(dn0 && dn1, "R10", "restart done", {dn0, dn1}, 3);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule